// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block derives the serial clock of an SPI master from a faster source clock. Alongside the clock level it produces two one-cycle strobes: one marks the cycle in which the serial clock goes high, and the other marks the cycle in which it goes low. The shift engine uses these strobes to launch and capture data without having to detect edges itself.

Timing is set through one 32-bit configuration word. Three 6-bit counts shape the waveform: a divide value, a terminal count and a high-phase count. Because the period and the high-phase length are programmed separately, the duty cycle can be set freely instead of being fixed at 50%. A single bit chooses the clock source. The output generator runs only while the transfer-enable input is high. Each new enable starts the waveform at phase zero. The timing used is the configuration held at the moment of that enable.

All outputs are registered. When the enable is sampled high at an edge, the serial clock is high and the rising strobe is set in the cycle that follows that edge.

Top module: `sckdiv_top`

## Requirements
- R1: The configuration word holds the terminal count in bits 5:0, the high-phase count in bits 11:6, the divide value in bits 17:12 and the source select in bit 31. Bits 30:18 have no effect on any output.
- R2: While enabled, the serial clock period is T+1 source cycles. T is the smaller of the divide value and the terminal count, after the R4 adjustment.
- R3: In each period the serial clock is high for the first H+1 cycles, counted from the rising strobe, and low for the remaining T-H cycles.
- R4: When the smaller of the divide value and the terminal count is 0, T is 1, so the serial clock runs at half the source rate.
- R5: When the high-phase count is T or more, H is T-1, so every period keeps at least one low cycle.
- R6: `rise_tick_o` is high for exactly the cycles in which `sck_o` has just gone from low to high. This includes the first cycle after an enable.
- R7: `fall_tick_o` is high for exactly the cycles in which `sck_o` has gone from high to low while enabled. It is never high together with `rise_tick_o`.
- R8: One cycle after an edge at which `run_i` is sampled low, `sck_o`, `rise_tick_o` and `fall_tick_o` are all low. The next enable restarts at phase zero.
- R9: A configuration write made while enabled has no effect on the running waveform. It takes effect at the next enable. A write on the same edge as the enable is used by that enable.
- R10: `src_sel_o` equals bit 31 of the most recently written word, starting one cycle after the write.
- R11: After reset all outputs are low and the configuration is all zero. An enable without a prior write therefore gives T=1 and H=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_data_i | input | 32 | Configuration word |
| run_i | input | 1 | Transfer enable; the clock runs while it is high |
| src_sel_o | output | 1 | Clock source select from the stored word |
| sck_o | output | 1 | Serial clock level |
| rise_tick_o | output | 1 | One-cycle strobe in the cycle the serial clock goes high |
| fall_tick_o | output | 1 | One-cycle strobe in the cycle the serial clock goes low |

## Verification
Two events can fall on the same clock edge: the loading of the configuration and the start of a new run. The bench raises the write strobe and the enable in the same cycle and expects the newly written timing from the very first period. The bench also issues a write part-way through a running waveform. It then requires the old period and high phase to continue unchanged until the enable has dropped and risen again.

// File: rtl/sckdiv_pkg.sv
`timescale 1ns/1ps
package sckdiv_pkg;
  localparam int unsigned CFG_W_DEF    = 32;
  localparam int unsigned CNT_W_DEF    = 6;
  localparam int unsigned TERM_LSB_DEF = 0;
  localparam int unsigned HI_LSB_DEF   = 6;
  localparam int unsigned DIV_LSB_DEF  = 12;
  localparam int unsigned SEL_BIT_DEF  = 31;
  localparam int unsigned SYNC_DEF     = 2;

  // Run state of the phase generator.
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_state_e;

  // Mask covering a field of the configuration word.
  function automatic logic [63:0] field_mask(int unsigned lsb, int unsigned width);
    logic [63:0] m;
    m = ((64'd1 << width) - 64'd1) << lsb;
    return m;
  endfunction
endpackage

// File: rtl/sckdiv_rst_sync.sv
`timescale 1ns/1ps
module sckdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sckdiv_cfg.sv
`timescale 1ns/1ps
module sckdiv_cfg import sckdiv_pkg::*; #(
  parameter int unsigned CFG_W    = CFG_W_DEF,
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned TERM_LSB = TERM_LSB_DEF,
  parameter int unsigned HI_LSB   = HI_LSB_DEF,
  parameter int unsigned DIV_LSB  = DIV_LSB_DEF,
  parameter int unsigned SEL_BIT  = SEL_BIT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] term_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             sel_o
);
  localparam logic [CFG_W-1:0] USED_MASK = CFG_W'(field_mask(TERM_LSB, CNT_W)
                                                | field_mask(HI_LSB, CNT_W)
                                                | field_mask(DIV_LSB, CNT_W)
                                                | field_mask(SEL_BIT, 1));
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Reserved bits are not stored (R1).
  logic unused_rsvd;
  assign unused_rsvd = ^(data_i & ~USED_MASK);

  // Shadow copy of the written word.
  logic [CNT_W-1:0] sh_term_q, sh_hi_q, sh_div_q;
  logic [CNT_W-1:0] sh_term_d, sh_hi_d, sh_div_d;
  logic             sh_sel_q, sh_sel_d;

  always_comb begin
    sh_term_d = sh_term_q;
    sh_hi_d   = sh_hi_q;
    sh_div_d  = sh_div_q;
    sh_sel_d  = sh_sel_q;
    if (wr_i) begin
      sh_term_d = data_i[TERM_LSB +: CNT_W];
      sh_hi_d   = data_i[HI_LSB +: CNT_W];
      sh_div_d  = data_i[DIV_LSB +: CNT_W];
      sh_sel_d  = data_i[SEL_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_term_q <= '0;
      sh_hi_q   <= '0;
      sh_div_q  <= '0;
      sh_sel_q  <= 1'b0;
    end else if (wr_i) begin
      sh_term_q <= sh_term_d;
      sh_hi_q   <= sh_hi_d;
      sh_div_q  <= sh_div_d;
      sh_sel_q  <= sh_sel_d;
    end
  end

  // Effective period and high phase, from the word about to be loaded.
  logic [CNT_W-1:0] lim, term_eff, hi_eff;
  always_comb begin
    lim      = (sh_div_d < sh_term_d) ? sh_div_d : sh_term_d;   // R2
    term_eff = (lim == '0) ? ONE : lim;                          // R4
    hi_eff   = (sh_hi_d >= term_eff) ? (term_eff - ONE) : sh_hi_d; // R5
  end

  // Active copy, loaded only while the generator is idle (R9).
  logic [CNT_W-1:0] act_term_q, act_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_term_q <= ONE;
      act_hi_q   <= '0;
    end else if (load_i) begin
      act_term_q <= term_eff;
      act_hi_q   <= hi_eff;
    end
  end

  assign term_o = act_term_q;
  assign hi_o   = act_hi_q;
  assign sel_o  = sh_sel_q;

  a_r4_term_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_term_q != '0);
  a_r5_hi_below_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_hi_q < act_term_q);
  a_r10_sel_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (sel_o == $past(data_i[SEL_BIT])));
endmodule

// File: rtl/sckdiv_phase.sv
`timescale 1ns/1ps
module sckdiv_phase import sckdiv_pkg::*; #(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] term_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             active_o,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W:0]   ONEW = (CNT_W+1)'(1);

  phase_state_e     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, rise_q, fall_q;
  logic             sck_d, rise_d, fall_d;
  logic [CNT_W:0]   fall_pt;
  logic             upd_en;

  assign fall_pt = {1'b0, hi_i} + ONEW;
  assign upd_en  = run_i | (st_q == PH_RUN);

  always_comb begin
    st_d  = run_i ? PH_RUN : PH_IDLE;
    cnt_d = '0;
    if (run_i && (st_q == PH_RUN) && (cnt_q != term_i)) begin
      cnt_d = cnt_q + ONE;
    end
    sck_d  = run_i && (cnt_d <= hi_i);
    rise_d = run_i && (cnt_d == '0);
    fall_d = run_i && ({1'b0, cnt_d} == fall_pt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign active_o = (st_q == PH_RUN);
  assign sck_o    = sck_q;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_RUN) |-> (cnt_q <= term_i));
  a_r6_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (sck_o && !$past(sck_o)));
  a_r6_edge_has_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> rise_o);
  a_r7_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!sck_o && $past(sck_o)));
  a_r7_ticks_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!sck_o && !rise_o && !fall_o));
endmodule

// File: rtl/sckdiv_top.sv
`timescale 1ns/1ps
module sckdiv_top import sckdiv_pkg::*; #(
  parameter int unsigned CFG_W    = CFG_W_DEF,
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned TERM_LSB = TERM_LSB_DEF,
  parameter int unsigned HI_LSB   = HI_LSB_DEF,
  parameter int unsigned DIV_LSB  = DIV_LSB_DEF,
  parameter int unsigned SEL_BIT  = SEL_BIT_DEF,
  parameter int unsigned SYNC_STG = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             run_i,
  output logic             src_sel_o,
  output logic             sck_o,
  output logic             rise_tick_o,
  output logic             fall_tick_o
);
  logic             rst_n_sync;
  logic             active;
  logic             load;
  logic [CNT_W-1:0] act_term, act_hi;

  sckdiv_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  assign load = !active;

  sckdiv_cfg #(
    .CFG_W(CFG_W), .CNT_W(CNT_W), .TERM_LSB(TERM_LSB),
    .HI_LSB(HI_LSB), .DIV_LSB(DIV_LSB), .SEL_BIT(SEL_BIT)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .load_i (load),
    .term_o (act_term),
    .hi_o   (act_hi),
    .sel_o  (src_sel_o)
  );

  sckdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .run_i    (run_i),
    .term_i   (act_term),
    .hi_i     (act_hi),
    .active_o (active),
    .sck_o    (sck_o),
    .rise_o   (rise_tick_o),
    .fall_o   (fall_tick_o)
  );
endmodule

// File: tb/sckdiv_top_tb_top.sv
`timescale 1ns/1ps
module sckdiv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_data;
  logic        run;
  logic        src_sel, sck, rise, fall;

  always #2 clk = ~clk;   // 250 MHz

  sckdiv_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_wr_i    (cfg_wr),
    .cfg_data_i  (cfg_data),
    .run_i       (run),
    .src_sel_o   (src_sel),
    .sck_o       (sck),
    .rise_tick_o (rise),
    .fall_tick_o (fall)
  );

  logic [2:0] exp_q[$];   // {sck, rise, fall}
  string      tag_q[$];
  int         nvec  = 0;
  int         nfail = 0;
  bit         done  = 1'b0;

  // Word layout per R1.
  function automatic logic [31:0] pack(bit sel, int dv, int hi, int term);
    return {sel, 13'd0, 6'(dv), 6'(hi), 6'(term)};
  endfunction

  // Expected waveform from R2..R5.
  task automatic push_run(int dv, int hi, int term, int n, string tag);
    int t;
    int h;
    t = (dv < term) ? dv : term;
    if (t == 0) t = 1;
    h = (hi >= t) ? t - 1 : hi;
    for (int k = 0; k < n; k++) begin
      int c;
      c = k % (t + 1);
      exp_q.push_back({c <= h, c == 0, c == h + 1});
      tag_q.push_back(tag);
    end
  endtask

  task automatic check1(string tag, logic got, logic exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] w);
    @(negedge clk);
    cfg_wr   = 1'b1;
    cfg_data = w;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic window(int dv, int hi, int term, int n, bit start_wr,
                        int mid_at, logic [31:0] mid_word, string tag);
    @(negedge clk);
    run = 1'b1;
    if (start_wr) begin
      cfg_wr   = 1'b1;
      cfg_data = pack(1'b0, dv, hi, term);
    end
    push_run(dv, hi, term, n, tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      if (k == mid_at) begin
        cfg_wr   = 1'b1;
        cfg_data = mid_word;
      end
    end
    run    = 1'b0;
    cfg_wr = 1'b0;
    exp_q.push_back(3'b000); tag_q.push_back("R8 idle");
    exp_q.push_back(3'b000); tag_q.push_back("R8 idle");
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare outputs 1 ns after each rising edge.
  always @(posedge clk) begin
    logic [2:0] e;
    string      t;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nvec++;
      if ({sck, rise, fall} !== e) begin
        nfail++;
        $display("FAIL %s: got sck/rise/fall=%b expected %b", t, {sck, rise, fall}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    cfg_wr   = 1'b0;
    cfg_data = '0;
    run      = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check1("R11 sck", sck, 1'b0);
    check1("R11 rise", rise, 1'b0);
    check1("R11 fall", fall, 1'b0);
    check1("R11 src_sel", src_sel, 1'b0);
    window(0, 0, 0, 6, 1'b0, -1, '0, "R11 default config");

    // R2 R3 R6 R7: even duty
    write_cfg(pack(1'b0, 7, 3, 7));
    window(7, 3, 7, 24, 1'b0, -1, '0, "R2 R3 R6 R7");
    // R4: zero counts give half rate; R5 clamp of high count
    write_cfg(pack(1'b0, 0, 5, 0));
    window(0, 5, 0, 10, 1'b0, -1, '0, "R4 R5");
    // R2 R3: slowest
    write_cfg(pack(1'b0, 63, 31, 63));
    window(63, 31, 63, 130, 1'b0, -1, '0, "R2 R3 slowest");
    // R5: high count beyond period
    write_cfg(pack(1'b0, 5, 9, 5));
    window(5, 9, 5, 14, 1'b0, -1, '0, "R5");
    // R2: smaller of divide and terminal wins, each way round
    write_cfg(pack(1'b0, 3, 1, 9));
    window(3, 1, 9, 12, 1'b0, -1, '0, "R2 divide smaller");
    write_cfg(pack(1'b0, 9, 1, 3));
    window(9, 1, 3, 12, 1'b0, -1, '0, "R2 terminal smaller");
    // R3 R7: one-cycle high phase
    write_cfg(pack(1'b0, 10, 0, 10));
    window(10, 0, 10, 23, 1'b0, -1, '0, "R3 R7 narrow high");
    // R1 R10: reserved bits set, source select set
    write_cfg(pack(1'b1, 2, 1, 2) | 32'h7FFC_0000);
    check1("R10 src_sel set", src_sel, 1'b1);
    window(2, 1, 2, 9, 1'b0, -1, '0, "R1 reserved bits");
    // R9: write during a run is deferred
    write_cfg(pack(1'b0, 3, 1, 3));
    window(3, 1, 3, 16, 1'b0, 5, pack(1'b0, 9, 4, 9), "R9 mid-run write");
    check1("R10 src_sel clear", src_sel, 1'b0);
    window(9, 4, 9, 24, 1'b0, -1, '0, "R9 deferred config");
    // R9: write on the enable edge
    window(2, 0, 2, 9, 1'b1, -1, '0, "R9 same-edge write");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule